// File: doc/BRIEF.md
# Frame Capture Sequencer with Descriptor Chain

This block decides when image frames are written to memory. Software raises a capture request; the sequencer does not start mid-frame but waits for the next frame-start pulse from the pixel path. It then marks the frame as being transferred until the matching frame-end pulse. In single-shot mode it stops after one frame. In continuous mode it asks for the next transfer descriptor after every frame and follows the chain until a descriptor ends it.

A descriptor ends the chain when its enable bit is clear or its next-descriptor address is zero. That drops the capture-active status and raises the list-done flag. Software can stop the sequencer gracefully with a disable pulse, which lets a frame in flight finish. It can also stop it at once with a soft reset pulse, which clears all state and flags. The bus master that fetches descriptors and moves pixels sits outside the block and talks to it through a request/acknowledge pair.

Top module: `frame_capture_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `capture_active`, `desc_req`, both event outputs and both sticky flags are 0.
- R2: A `cap_req` pulse is accepted only when the sequencer is idle: `capture_active` is low and the previous cycle was not a stop. An accepted request raises `capture_active` in the next cycle and latches `continuous`. Requests made while busy, or in the cycle just after a stop, are ignored.
- R3: After acceptance, the transfer begins at the first `frame_start` seen in a later cycle. A `frame_end` that arrives before that transfer has begun produces no transfer-done event.
- R4: A `frame_end` during a transfer pulses `xfer_done_evt` for exactly one cycle, starting the next cycle, and sets the sticky `xfer_done`.
- R5: In single-shot mode (latched `continuous`=0), `capture_active` is low in the cycle after the first transfer's `frame_end`, and no descriptor is requested.
- R6: In continuous mode, `desc_req` rises in the cycle after `frame_end` and stays high until a cycle with `desc_ack`=1.
- R7: An acknowledged descriptor with `desc_enable`=1 and `desc_next`≠0 keeps `capture_active` high and returns to waiting for a frame start.
- R8: An acknowledged descriptor with `desc_enable`=0 or `desc_next`=0 drops `capture_active` in the next cycle, pulses `list_done_evt` for one cycle and sets the sticky `list_done`.
- R9: A `sw_disable` pulse has a different effect in each phase. While waiting for a frame start, it stops capture the next cycle. During a transfer, the frame completes with its done event and capture then stops. During a descriptor fetch, capture stops when that fetch is acknowledged. In no case does a disable request a descriptor or set `list_done`.
- R10: A `sw_reset` pulse overrides every other input. In the next cycle the sequencer is idle and both sticky flags and both events are 0.
- R11: `xfer_done_clr` and `list_done_clr` clear their sticky flag in the next cycle. An event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req | input | 1 | Capture request pulse |
| continuous | input | 1 | 1 = continuous, 0 = single shot; latched on request |
| sw_disable | input | 1 | Graceful stop pulse |
| sw_reset | input | 1 | Immediate soft reset pulse |
| frame_start | input | 1 | Frame-start pulse from pixel path |
| frame_end | input | 1 | Frame-end pulse from pixel path |
| desc_req | output | 1 | Descriptor fetch request |
| desc_ack | input | 1 | Descriptor valid / fetch done |
| desc_enable | input | 1 | Fetched descriptor enable bit |
| desc_next | input | ADDR_W | Fetched next-descriptor address |
| xfer_done_clr | input | 1 | Write-one-to-clear for `xfer_done` |
| list_done_clr | input | 1 | Write-one-to-clear for `list_done` |
| capture_active | output | 1 | Capture in progress |
| xfer_done_evt | output | 1 | One-cycle frame transfer done event |
| list_done_evt | output | 1 | One-cycle chain end event |
| xfer_done | output | 1 | Sticky transfer-done flag |
| list_done | output | 1 | Sticky list-done flag |

## Verification
Every output is registered or decoded from the state register. A stimulus applied in one cycle therefore shows at the ports exactly one clock edge later, and the bench relies on that: it drives inputs just after the falling edge and compares outputs at the next falling edge. At that point they are checked against a cycle model that was advanced with the same inputs. Directed sequences cover the multi-cycle effects, such as a held `desc_req`, a disable during a transfer and a late `frame_start`. These sequences count the edges between the cause and the effect, and they check named ports in the cycle where the change is due.

// File: rtl/frame_capture_ctrl.sv
module frame_capture_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              continuous,
  input  logic              sw_disable,
  input  logic              sw_reset,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic              desc_req,
  input  logic              desc_ack,
  input  logic              desc_enable,
  input  logic [ADDR_W-1:0] desc_next,
  input  logic              xfer_done_clr,
  input  logic              list_done_clr,
  output logic              capture_active,
  output logic              xfer_done_evt,
  output logic              list_done_evt,
  output logic              xfer_done,
  output logic              list_done
);

  typedef enum logic [2:0] {IDLE, WAIT_SOF, XFER, FETCH_DESC, DONE} state_t;

  state_t state, state_nx;
  logic   cont_q, stop_q;
  logic   stop_nx, xe_nx, le_nx;

  wire desc_ok = desc_enable && (desc_next != '0);

  always_comb begin
    state_nx = state;
    stop_nx  = stop_q;
    xe_nx    = 1'b0;
    le_nx    = 1'b0;
    unique case (state)
      IDLE: if (cap_req) begin
        state_nx = WAIT_SOF;
        stop_nx  = 1'b0;
      end
      WAIT_SOF:
        if (sw_disable)       state_nx = DONE;
        else if (frame_start) state_nx = XFER;
      XFER: begin
        if (sw_disable) stop_nx = 1'b1;
        if (frame_end) begin
          xe_nx    = 1'b1;
          state_nx = (!cont_q || stop_nx) ? DONE : FETCH_DESC;
        end
      end
      FETCH_DESC: begin
        if (sw_disable) stop_nx = 1'b1;
        if (desc_ack) begin
          if (stop_nx)       state_nx = DONE;
          else if (desc_ok)  state_nx = WAIT_SOF;
          else begin
            state_nx = DONE;
            le_nx    = 1'b1;
          end
        end
      end
      DONE:    state_nx = IDLE;
      default: state_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= IDLE;
      cont_q        <= 1'b0;
      stop_q        <= 1'b0;
      xfer_done_evt <= 1'b0;
      list_done_evt <= 1'b0;
      xfer_done     <= 1'b0;
      list_done     <= 1'b0;
    end else if (sw_reset) begin
      state         <= IDLE;
      cont_q        <= 1'b0;
      stop_q        <= 1'b0;
      xfer_done_evt <= 1'b0;
      list_done_evt <= 1'b0;
      xfer_done     <= 1'b0;
      list_done     <= 1'b0;
    end else begin
      state         <= state_nx;
      stop_q        <= stop_nx;
      if (state == IDLE && cap_req) cont_q <= continuous;
      xfer_done_evt <= xe_nx;
      list_done_evt <= le_nx;
      xfer_done     <= xe_nx | (xfer_done & ~xfer_done_clr);
      list_done     <= le_nx | (list_done & ~list_done_clr);
    end
  end

  assign capture_active = (state == WAIT_SOF) || (state == XFER) || (state == FETCH_DESC);
  assign desc_req       = (state == FETCH_DESC);

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_evt |-> xfer_done); // R4
  AST_XFER_AFTER_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == XFER) |-> $past(frame_start)); // R3
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XFER && frame_end && !cont_q && !sw_reset) |=> !capture_active && !desc_req); // R5
  AST_LIST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    list_done_evt |-> !capture_active && list_done); // R8
  AST_CHAIN_GOES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && desc_ack && desc_ok && !stop_q && !sw_disable && !sw_reset) |=> capture_active && !desc_req); // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> !capture_active && !xfer_done && !list_done && !xfer_done_evt); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_ack && !sw_reset) |=> desc_req); // R6

endmodule

// File: tb/frame_capture_ctrl_test.sv
module frame_capture_ctrl_test;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_req = 0, continuous = 0, sw_disable = 0, sw_reset = 0;
  logic frame_start = 0, frame_end = 0, desc_ack = 0, desc_enable = 0;
  logic [AW-1:0] desc_next = '0;
  logic xfer_done_clr = 0, list_done_clr = 0;
  logic desc_req, capture_active, xfer_done_evt, list_done_evt, xfer_done, list_done;

  int tests = 0, fails = 0;

  frame_capture_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .continuous(continuous),
    .sw_disable(sw_disable), .sw_reset(sw_reset), .frame_start(frame_start),
    .frame_end(frame_end), .desc_req(desc_req), .desc_ack(desc_ack),
    .desc_enable(desc_enable), .desc_next(desc_next), .xfer_done_clr(xfer_done_clr),
    .list_done_clr(list_done_clr), .capture_active(capture_active),
    .xfer_done_evt(xfer_done_evt), .list_done_evt(list_done_evt),
    .xfer_done(xfer_done), .list_done(list_done));

  always #4 clk = ~clk;

  // cycle model: 0 idle, 1 wait frame start, 2 transfer, 3 fetch, 4 stopped
  int m_st = 0;
  bit m_cont = 0, m_stop = 0, m_xe = 0, m_le = 0, m_xd = 0, m_ld = 0;

  function automatic bit exp_active(int st);
    return st == 1 || st == 2 || st == 3;
  endfunction

  task automatic check(string tag, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 capture_active", capture_active, exp_active(m_st));
    check("R6 desc_req", desc_req, m_st == 3);
    check("R4 xfer_done_evt", xfer_done_evt, m_xe);
    check("R8 list_done_evt", list_done_evt, m_le);
    check("R11 xfer_done", xfer_done, m_xd);
    check("R11 list_done", list_done, m_ld);
  endtask

  task automatic model_step();
    bit stp, xe, le;
    if (sw_reset) begin
      m_st = 0; m_cont = 0; m_stop = 0; m_xe = 0; m_le = 0; m_xd = 0; m_ld = 0;
      return;
    end
    stp = m_stop; xe = 0; le = 0;
    case (m_st)
      0: if (cap_req) begin m_st = 1; m_cont = continuous; stp = 0; end
      1: if (sw_disable) m_st = 4; else if (frame_start) m_st = 2;
      2: begin
        if (sw_disable) stp = 1;
        if (frame_end) begin xe = 1; m_st = (!m_cont || stp) ? 4 : 3; end
      end
      3: begin
        if (sw_disable) stp = 1;
        if (desc_ack) begin
          if (stp) m_st = 4;
          else if (desc_enable && desc_next != 0) m_st = 1;
          else begin m_st = 4; le = 1; end
        end
      end
      default: m_st = 0;
    endcase
    m_stop = stp; m_xe = xe; m_le = le;
    m_xd = xe | (m_xd & ~xfer_done_clr);
    m_ld = le | (m_ld & ~list_done_clr);
  endtask

  task automatic clear_in();
    cap_req = 0; sw_disable = 0; sw_reset = 0; frame_start = 0; frame_end = 0;
    desc_ack = 0; desc_enable = 0; desc_next = '0; xfer_done_clr = 0; list_done_clr = 0;
  endtask

  // inputs already set after the falling edge; advance one clock, compare
  task automatic tick();
    model_step();
    @(negedge clk);
    compare_all();
    clear_in();
  endtask

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    check("R1 active in reset", capture_active, 1'b0);
    check("R1 desc_req in reset", desc_req, 1'b0);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    check("R1 flags after reset", xfer_done | list_done, 1'b0);

    // R3: frame_end before any frame_start gives no done event
    cap_req = 1; continuous = 0; frame_start = 1; tick();
    check("R2 accepted", capture_active, 1'b1);
    frame_end = 1; tick();
    check("R3 no early done", xfer_done_evt, 1'b0);
    cap_req = 1; continuous = 1; tick();          // ignored while busy (R2)
    frame_start = 1; tick();
    frame_end = 1; tick();
    check("R4 event", xfer_done_evt, 1'b1);
    check("R5 single shot stops", capture_active, 1'b0);
    check("R5 no fetch", desc_req, 1'b0);
    cap_req = 1; tick();                            // R2: dropped in the stop cycle
    check("R2 ignored after stop", capture_active, 1'b0);
    check("R4 one-cycle event", xfer_done_evt, 1'b0);
    xfer_done_clr = 1; tick();
    check("R11 cleared", xfer_done, 1'b0);

    // continuous chain: one good descriptor then a zero address
    cap_req = 1; continuous = 1; tick();
    frame_start = 1; tick();
    frame_end = 1; tick();
    check("R6 fetch req", desc_req, 1'b1);
    tick(); tick();
    check("R6 held without ack", desc_req, 1'b1);
    desc_ack = 1; desc_enable = 1; desc_next = 32'h100; tick();
    check("R7 chain continues", capture_active, 1'b1);
    frame_start = 1; tick();
    frame_end = 1; xfer_done_clr = 1; tick();
    check("R11 set wins over clear", xfer_done, 1'b1);
    desc_ack = 1; desc_enable = 1; desc_next = '0; tick();
    check("R8 list end", list_done_evt, 1'b1);
    check("R8 inactive", capture_active, 1'b0);
    tick();

    // R9: disable during transfer lets the frame finish
    cap_req = 1; continuous = 1; tick();
    frame_start = 1; tick();
    sw_disable = 1; tick();
    check("R9 still active", capture_active, 1'b1);
    frame_end = 1; tick();
    check("R9 frame finished", xfer_done_evt, 1'b1);
    check("R9 stopped no fetch", capture_active | desc_req, 1'b0);
    tick();

    // R10: soft reset mid transfer
    cap_req = 1; continuous = 1; tick();
    frame_start = 1; tick();
    sw_reset = 1; frame_end = 1; tick();
    check("R10 reset wins", capture_active | xfer_done | list_done | xfer_done_evt, 1'b0);

    // constrained random
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4000; i++) begin
      cap_req       = ($urandom % 8) == 0;
      continuous    = ($urandom % 4) != 0;
      sw_disable    = ($urandom % 60) == 0;
      sw_reset      = ($urandom % 300) == 0;
      frame_start   = ($urandom % 6) == 0;
      frame_end     = ($urandom % 6) == 0;
      desc_ack      = ($urandom % 3) == 0;
      desc_enable   = ($urandom % 5) != 0;
      desc_next     = (($urandom % 5) == 0) ? '0 : AW'($urandom);
      xfer_done_clr = ($urandom % 10) == 0;
      list_done_clr = ($urandom % 10) == 0;
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule